// File: doc/BRIEF.md
# SDRAM refresh and self-refresh sequencer

This block lives inside an SDRAM controller and is the only source of refresh traffic. A free-running interval counter, sized from the clock frequency, marks every slot in which one distributed auto-refresh is owed; the slot period keeps the spacing at or below 15.625 µs. When a refresh is owed, the block raises a bus request towards the main controller. Once the bus is granted it closes all banks with a precharge-all, waits the row-precharge time, issues the auto-refresh and then keeps the bus with NOPs for the refresh cycle time before handing it back. A request left ungranted past the following slot raises an overdue flag.

A power-down request moves the memory into self-refresh. The block takes the bus, precharges all banks, and sends the refresh encoding with the clock-enable line low in that same cycle. Clock enable then stays low for as long as the memory sleeps. A wake request is honoured only after the minimum self-refresh residency. On exit the block raises clock enable, sends NOPs for the exit-to-command time (never fewer than two clocks), releases the bus and restarts the interval counter from zero. Periodic refresh therefore resumes on a full, fresh interval. The memory keeps its own row counter, so the block holds no row address.

Top module: `sdr_refresh_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, cke is 1, the command pins show NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1), and bus_req, busy and overdue are 0.
- R2: With bus_grant held high, consecutive auto-refresh commands (0,0,0,1 with cke high) are exactly REFI_CYC cycles apart, where REFI_CYC = CLK_KHZ*15625/1000000. The first one comes REFI_CYC+2+T_RP cycles after reset release.
- R3: While a refresh is owed and bus_grant is low, bus_req stays 1, busy stays 0 and the pins show only NOP. The precharge goes out in the cycle after bus_grant is first sampled high with bus_req high.
- R4: Every refresh sequence starts with a precharge-all (0,0,1,0 with a10 = 1). The refresh command follows exactly T_RP cycles after that precharge, with NOPs in between.
- R5: After an auto-refresh, the block drives NOPs and keeps bus_req and busy at 1 through the following T_RFC-1 cycles. bus_req drops exactly T_RFC cycles after the refresh command.
- R6: If a request is still ungranted when the next interval slot ends, overdue rises REFI_CYC-1 cycles after bus_req rose. It stays 1 through the refresh command and is 0 in the cycle after it.
- R7: A one-cycle pulse on sr_enter_req while idle is followed by a precharge-all three cycles later. T_RP cycles after that comes the refresh encoding with cke = 0 in the same cycle. cke then stays 0, with no refresh, for as long as no wake is accepted.
- R8: sr_wake_req is not acted on earlier than T_RAS cycles after the self-refresh entry command. With wake held high, cke returns to 1 exactly T_RAS cycles after that command.
- R9: From the cycle cke rises, the pins show NOP for XSR_CYC = max(T_XSR, 2) cycles. bus_req drops exactly XSR_CYC cycles after cke rose.
- R10: After self-refresh exit, the next auto-refresh precharge comes REFI_CYC+2 cycles after bus_req dropped, and the refresh command comes T_RP cycles after that precharge.
- R11: A self-refresh request that arrives during an auto-refresh sequence waits until that sequence ends. bus_req drops T_RFC cycles after the refresh, and the self-refresh precharge follows two cycles after the release.
- R12: sr_wake_req pulsed outside self-refresh has no effect: cke stays 1 and no command is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sr_enter_req | input | 1 | One-cycle request to enter self-refresh |
| sr_wake_req | input | 1 | Level request to leave self-refresh |
| bus_grant | input | 1 | Command bus granted by the main controller |
| bus_req | output | 1 | Command bus wanted or held by this block |
| busy | output | 1 | Block is driving the command bus |
| overdue | output | 1 | A refresh request outlived a whole interval |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Memory clock enable |
| a10 | output | 1 | Address bit 10, high selects all banks on precharge |

## Verification
Periodic refresh is tried with grant held high, which pins down interval spacing and the precharge, refresh and release offsets. It is also tried with grant withheld across a slot boundary, which separates correct waiting and the overdue timing from a block that issues commands without the bus. Self-refresh entry is tried from idle and also in the middle of an auto-refresh sequence. The second case tells deferral apart from preemption. Exit is tried with wake raised at once, which exposes an early exit, and after a long sleep, which shows that cke holds low indefinitely. A stray wake pulse while idle and the first refresh after exit tell apart a counter restarted on exit from one left running.

// File: rtl/sdr_refresh_pkg.sv
// Shared types for the SDRAM refresh sequencer.
// Assumes: command pins are active-low, ordered cs_n, ras_n, cas_n, we_n.
package sdr_refresh_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_REQ,
        ST_PRE,
        ST_WAIT_RP,
        ST_AREF,
        ST_WAIT_RFC,
        ST_SR_ENT,
        ST_SR_HOLD,
        ST_SR_EXIT
    } seq_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdr_cmd_t;

    localparam sdr_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdr_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sdr_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdr_refi_timer.sv
// Refresh interval timer.
// Counts clock cycles modulo REFI_CYC and pulses tick in the last cycle of
// each slot. hold_clr keeps the count at zero (used during self-refresh) so
// that counting restarts from a full interval once it is released.
module sdr_refi_timer #(
    parameter int REFI_CYC = 1953
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_clr,
    output logic tick
);
    localparam int CW = (REFI_CYC > 2) ? $clog2(REFI_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(REFI_CYC - 1);

    logic [CW-1:0] cnt;

    // Advance the slot counter, wrapping at the slot length.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_clr) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Slot end marker.
    always_comb begin
        tick = !hold_clr && (cnt == LAST);
    end

    assert_slot_wraps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == '0));

    assert_slot_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/sdr_delay_timer.sv
// Shared wait timer for tRP, tRFC, tRAS residency and exit waits.
// Assumes: only one wait runs at a time. load presets the count; the count
// then steps down once per cycle and rests at zero, where done is high.
module sdr_delay_timer #(
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    output logic          done
);
    logic [DW-1:0] cnt;

    // Preset on load, otherwise count down to zero and stay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Wait finished.
    always_comb begin
        done = (cnt == '0);
    end

    assert_wait_steps_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sdr_refresh_pending.sv
// Request tracker.
// Holds the owed-refresh flag, the overdue flag and the latched
// self-refresh request. A slot tick sets the owed flag. A second tick that
// finds the owed flag still set raises overdue. An issued refresh or a
// self-refresh entry clears both flags.
module sdr_refresh_pending (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic aref_issue,
    input  logic sre_issue,
    input  logic sr_enter_req,
    output logic ref_pending,
    output logic overdue,
    output logic sr_pending
);
    // Owed-refresh and overdue flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_pending <= 1'b0;
            overdue     <= 1'b0;
        end else if (tick) begin
            ref_pending <= 1'b1;
            overdue     <= ref_pending && !aref_issue;
        end else if (aref_issue || sre_issue) begin
            ref_pending <= 1'b0;
            overdue     <= 1'b0;
        end
    end

    // Latched self-refresh entry request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_pending <= 1'b0;
        end else if (sre_issue) begin
            sr_pending <= 1'b0;
        end else if (sr_enter_req) begin
            sr_pending <= 1'b1;
        end
    end

    assert_sr_request_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_enter_req && !sre_issue) |=> sr_pending);

endmodule

// File: rtl/sdr_refresh_fsm.sv
// Refresh sequencing state machine.
// Arbitrates between self-refresh entry and auto-refresh (self-refresh
// wins when both wait in idle). It waits for the bus grant, precharges all
// banks, waits tRP, then issues either an auto-refresh followed by a tRFC
// hold, or a self-refresh entry followed by the residency wait and the
// exit NOPs. Outputs decode from the state register only, so no input
// reaches a pin in the same cycle.
// Assumes: bus_grant stays high once given until bus_req drops;
// T_RP, T_RFC, T_RAS >= 2 and XSR_CYC >= 2.
module sdr_refresh_fsm
    import sdr_refresh_pkg::*;
#(
    parameter int T_RP    = 3,
    parameter int T_RFC   = 8,
    parameter int T_RAS   = 6,
    parameter int XSR_CYC = 10,
    parameter int DW      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_pending,
    input  logic          sr_pending,
    input  logic          sr_wake,
    input  logic          bus_grant,
    input  logic          wait_done,
    output logic          tmr_load,
    output logic [DW-1:0] tmr_val,
    output logic          aref_issue,
    output logic          sre_issue,
    output logic          sr_active,
    output logic          bus_req,
    output logic          busy,
    output sdr_cmd_t      cmd,
    output logic          cke,
    output logic          a10
);
    seq_state_t state, state_nx;
    logic       kind_sr;
    logic       go_exit;

    // Exit permitted once residency has elapsed and wake is requested.
    always_comb begin
        go_exit = (state == ST_SR_HOLD) && wait_done && sr_wake;
    end

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (sr_pending || ref_pending) state_nx = ST_REQ;
            ST_REQ:      if (bus_grant) state_nx = ST_PRE;
            ST_PRE:      state_nx = ST_WAIT_RP;
            ST_WAIT_RP:  if (wait_done) state_nx = kind_sr ? ST_SR_ENT : ST_AREF;
            ST_AREF:     state_nx = ST_WAIT_RFC;
            ST_WAIT_RFC: if (wait_done) state_nx = ST_IDLE;
            ST_SR_ENT:   state_nx = ST_SR_HOLD;
            ST_SR_HOLD:  if (go_exit) state_nx = ST_SR_EXIT;
            ST_SR_EXIT:  if (wait_done) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Sequence kind, fixed when a sequence leaves idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_sr <= 1'b0;
        end else if (state == ST_IDLE) begin
            kind_sr <= sr_pending;
        end
    end

    // Wait timer presets; each wait ends one cycle before the next command.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_PRE:     begin tmr_load = 1'b1; tmr_val = DW'(T_RP - 2);    end
            ST_AREF:    begin tmr_load = 1'b1; tmr_val = DW'(T_RFC - 2);   end
            ST_SR_ENT:  begin tmr_load = 1'b1; tmr_val = DW'(T_RAS - 2);   end
            ST_SR_HOLD: begin tmr_load = go_exit; tmr_val = DW'(XSR_CYC - 1); end
            default:    begin tmr_load = 1'b0; tmr_val = '0;               end
        endcase
    end

    // Pin and handshake decode from the registered state.
    always_comb begin
        unique case (state)
            ST_PRE:              cmd = CMD_PRE;
            ST_AREF, ST_SR_ENT:  cmd = CMD_REF;
            default:             cmd = CMD_NOP;
        endcase
        a10        = (state == ST_PRE);
        cke        = !((state == ST_SR_ENT) || (state == ST_SR_HOLD));
        bus_req    = (state != ST_IDLE);
        busy       = (state != ST_IDLE) && (state != ST_REQ);
        aref_issue = (state == ST_AREF);
        sre_issue  = (state == ST_SR_ENT);
        sr_active  = (state == ST_SR_ENT) || (state == ST_SR_HOLD) ||
                     (state == ST_SR_EXIT);
    end

    assert_precharge_after_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRE) |-> $past(bus_grant));

    assert_precharge_all_banks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |-> a10);

    assert_cke_falls_on_refresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (cmd == CMD_REF));

    assert_exit_after_residency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> ($past(wait_done) && $past(sr_wake)));

    assert_exit_starts_with_nop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> ((cmd == CMD_NOP) && bus_req));

endmodule

// File: rtl/sdr_refresh_seq.sv
// SDRAM refresh and self-refresh sequencer, top level.
// Ties the slot timer, request tracker, shared wait timer and sequencing
// state machine together. Timing parameters are in clock cycles; the
// refresh slot length is derived from CLK_KHZ for a 15.625 us period.
// Assumes: clock is running and stable whenever the block is out of reset.
module sdr_refresh_seq
    import sdr_refresh_pkg::*;
#(
    parameter int CLK_KHZ = 125000,
    parameter int T_RP    = 3,
    parameter int T_RFC   = 8,
    parameter int T_RAS   = 6,
    parameter int T_XSR   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sr_enter_req,
    input  logic sr_wake_req,
    input  logic bus_grant,
    output logic bus_req,
    output logic busy,
    output logic overdue,
    output logic cs_n,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic cke,
    output logic a10
);
    localparam longint REFI_L   = (longint'(CLK_KHZ) * 64'd15625) / 64'd1000000;
    localparam int     REFI_CYC = int'(REFI_L);
    localparam int     XSR_CYC  = max2(T_XSR, 2);
    localparam int     WAIT_MAX = max2(max2(T_RP, T_RFC), max2(T_RAS, XSR_CYC));
    localparam int     DW       = $clog2(WAIT_MAX + 1);

    logic          tick;
    logic          ref_pending;
    logic          sr_pending;
    logic          aref_issue;
    logic          sre_issue;
    logic          sr_active;
    logic          tmr_load;
    logic [DW-1:0] tmr_val;
    logic          wait_done;
    sdr_cmd_t      cmd;

    sdr_refi_timer #(.REFI_CYC(REFI_CYC)) u_refi (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_clr (sr_active),
        .tick     (tick)
    );

    sdr_refresh_pending u_pend (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .aref_issue   (aref_issue),
        .sre_issue    (sre_issue),
        .sr_enter_req (sr_enter_req),
        .ref_pending  (ref_pending),
        .overdue      (overdue),
        .sr_pending   (sr_pending)
    );

    sdr_delay_timer #(.DW(DW)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (wait_done)
    );

    sdr_refresh_fsm #(
        .T_RP    (T_RP),
        .T_RFC   (T_RFC),
        .T_RAS   (T_RAS),
        .XSR_CYC (XSR_CYC),
        .DW      (DW)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_pending (ref_pending),
        .sr_pending  (sr_pending),
        .sr_wake     (sr_wake_req),
        .bus_grant   (bus_grant),
        .wait_done   (wait_done),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .aref_issue  (aref_issue),
        .sre_issue   (sre_issue),
        .sr_active   (sr_active),
        .bus_req     (bus_req),
        .busy        (busy),
        .cmd         (cmd),
        .cke         (cke),
        .a10         (a10)
    );

    // Split the command struct onto the pins.
    always_comb begin
        cs_n  = cmd.cs_n;
        ras_n = cmd.ras_n;
        cas_n = cmd.cas_n;
        we_n  = cmd.we_n;
    end

    assert_overdue_while_requesting_R6: assert property (@(posedge clk) disable iff (!rst_n)
        overdue |-> bus_req);

    assert_no_refresh_in_self_refresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && !$fell(cke)) |-> (cmd == CMD_NOP));

endmodule

// File: tb/sdr_refresh_seq_tb.sv
// Scoreboard bench: the driver pushes predicted pin events with their cycle,
// and the monitor pops and compares each event the design produces.
module sdr_refresh_seq_tb;

    localparam int CLK_KHZ  = 125000;
    localparam int T_RP     = 3;
    localparam int T_RFC    = 8;
    localparam int T_RAS    = 6;
    localparam int T_XSR    = 1;
    localparam int REFI     = CLK_KHZ * 15625 / 1000000;
    localparam int XSR_CYC  = (T_XSR < 2) ? 2 : T_XSR;

    localparam int EV_PRE = 1, EV_AREF = 2, EV_SRE = 3, EV_SRX = 4, EV_REL = 5, EV_BAD = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sr_enter_req = 1'b0;
    logic sr_wake_req = 1'b0;
    logic bus_grant = 1'b1;
    logic bus_req, busy, overdue, cs_n, ras_n, cas_n, we_n, cke, a10;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int    q_cyc[$];
    int    q_code[$];
    string q_tag[$];

    always #4 clk = ~clk;

    sdr_refresh_seq #(
        .CLK_KHZ (CLK_KHZ),
        .T_RP    (T_RP),
        .T_RFC   (T_RFC),
        .T_RAS   (T_RAS),
        .T_XSR   (T_XSR)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sr_enter_req (sr_enter_req),
        .sr_wake_req  (sr_wake_req),
        .bus_grant    (bus_grant),
        .bus_req      (bus_req),
        .busy         (busy),
        .overdue      (overdue),
        .cs_n         (cs_n),
        .ras_n        (ras_n),
        .cas_n        (cas_n),
        .we_n         (we_n),
        .cke          (cke),
        .a10          (a10)
    );

    always @(posedge clk) begin
        if (rst_n) cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    task automatic expect_ev(input int c, input int code, input string tag);
        q_cyc.push_back(c);
        q_code.push_back(code);
        q_tag.push_back(tag);
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Monitor: classify pin activity each cycle and compare with predictions.
    logic prev_cke = 1'b1;
    logic prev_req = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            int code;
            code = 0;
            if ({cs_n, ras_n, cas_n, we_n} == 4'b0010)      code = a10 ? EV_PRE : EV_BAD;
            else if ({cs_n, ras_n, cas_n, we_n} == 4'b0001) code = cke ? EV_AREF : EV_SRE;
            else if (!cs_n && {ras_n, cas_n, we_n} != 3'b111) code = EV_BAD;
            else if (cke && !prev_cke)                     code = EV_SRX;
            else if (!bus_req && prev_req)                 code = EV_REL;
            if (code != 0) begin
                if (q_cyc.size() == 0) begin
                    check(1'b0, "R12", code, 0);
                end else begin
                    int    ec, ek;
                    string et;
                    ec = q_cyc.pop_front();
                    ek = q_code.pop_front();
                    et = q_tag.pop_front();
                    check(code == ek, et, code, ek);
                    check(cyc == ec, et, cyc, ec);
                end
            end
            prev_cke = cke;
            prev_req = bus_req;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog at cycle %0d: actual 1 expected 0", cyc);
        finish_run();
    end

    // Driver: stimulus plus predicted events per requirement.
    initial begin
        int g, m, e, x, r, q, e2, base;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(cke == 1'b1, "R1", cke, 1);
        check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        check(bus_req == 1'b0 && busy == 1'b0, "R1", {bus_req, busy}, 0);
        check(overdue == 1'b0, "R1", overdue, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(cke == 1'b1 && bus_req == 1'b0, "R1", {cke, bus_req}, 2);

        // Periodic refresh, grant held high.
        for (int i = 1; i <= 2; i++) begin
            base = i * REFI + 2;
            expect_ev(base, EV_PRE, "R4");
            expect_ev(base + T_RP, EV_AREF, "R2");
            expect_ev(base + T_RP + T_RFC, EV_REL, "R5");
        end

        // Stray wake while idle.
        wait_cyc(100);
        sr_wake_req = 1'b1;
        wait_cyc(101);
        sr_wake_req = 1'b0;
        wait_cyc(103);
        check(cke == 1'b1, "R12", cke, 1);

        wait_cyc(REFI + 2 + T_RP + 1);
        check(busy == 1'b1 && bus_req == 1'b1, "R5", {busy, bus_req}, 3);

        // Withheld grant and overdue.
        wait_cyc(3 * REFI - 10);
        bus_grant = 1'b0;
        wait_cyc(3 * REFI + 2);
        check(bus_req == 1'b1 && busy == 1'b0, "R3", {bus_req, busy}, 2);
        wait_cyc(4 * REFI - 1);
        check(overdue == 1'b0, "R6", overdue, 0);
        wait_cyc(4 * REFI);
        check(overdue == 1'b1, "R6", overdue, 1);
        g = 4 * REFI + 5;
        expect_ev(g + 1, EV_PRE, "R3");
        expect_ev(g + 1 + T_RP, EV_AREF, "R4");
        expect_ev(g + 1 + T_RP + T_RFC, EV_REL, "R5");
        wait_cyc(g);
        bus_grant = 1'b1;
        wait_cyc(g + 1 + T_RP);
        check(overdue == 1'b1, "R6", overdue, 1);
        wait_cyc(g + 2 + T_RP);
        check(overdue == 1'b0, "R6", overdue, 0);

        // Self-refresh request during an auto-refresh.
        m = 5 * REFI + 2 + T_RP;
        e = m + T_RFC + 2 + T_RP;
        expect_ev(5 * REFI + 2, EV_PRE, "R4");
        expect_ev(m, EV_AREF, "R2");
        expect_ev(m + T_RFC, EV_REL, "R11");
        expect_ev(m + T_RFC + 2, EV_PRE, "R11");
        expect_ev(e, EV_SRE, "R11");
        wait_cyc(m);
        sr_enter_req = 1'b1;
        wait_cyc(m + 1);
        sr_enter_req = 1'b0;

        // Early wake: exit only after residency.
        wait_cyc(e);
        sr_wake_req = 1'b1;
        x = e + T_RAS;
        expect_ev(x, EV_SRX, "R8");
        expect_ev(x + XSR_CYC, EV_REL, "R9");
        wait_cyc(x - 1);
        check(cke == 1'b0, "R8", cke, 0);
        wait_cyc(x + 1);
        check({cs_n, ras_n, cas_n, we_n} == 4'b0111 && cke == 1'b1, "R9",
              {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        wait_cyc(x + XSR_CYC);
        sr_wake_req = 1'b0;

        // First refresh after exit uses a fresh interval.
        r = x + XSR_CYC;
        expect_ev(r + REFI + 2, EV_PRE, "R10");
        expect_ev(r + REFI + 2 + T_RP, EV_AREF, "R10");
        expect_ev(r + REFI + 2 + T_RP + T_RFC, EV_REL, "R5");

        // Self-refresh from idle with a long sleep.
        q = r + REFI + 2 + T_RP + T_RFC + 5;
        e2 = q + 3 + T_RP;
        expect_ev(q + 3, EV_PRE, "R7");
        expect_ev(e2, EV_SRE, "R7");
        wait_cyc(q);
        sr_enter_req = 1'b1;
        wait_cyc(q + 1);
        sr_enter_req = 1'b0;
        wait_cyc(e2 + 5000);
        check(cke == 1'b0, "R7", cke, 0);
        check(busy == 1'b1, "R7", busy, 1);
        sr_wake_req = 1'b1;
        expect_ev(e2 + 5001, EV_SRX, "R8");
        expect_ev(e2 + 5001 + XSR_CYC, EV_REL, "R9");
        wait_cyc(e2 + 5001 + XSR_CYC + 10);
        sr_wake_req = 1'b0;
        check(q_cyc.size() == 0, "R9", q_cyc.size(), 0);
        finish_run();
    end

endmodule